// File: doc/BRIEF.md
# I2C Memory Read Target

This block is the read side of a serial memory that sits on an I2C bus. It listens on open-drain clock and data lines, sampled by a fast system clock, and serves reads from two spaces. The first is a 32 KB byte array. The second is a separate 64-byte identification page. Storage is outside the block and is reached through two simple synchronous read ports: a one-cycle enable with an address, and the data returned on the next cycle.

A controller loads the address by starting a write: it sends the select byte, then the two address bytes, and does not send a Stop. It then issues a repeated Start and sends the select byte again with the read bit set. The controller can also start a read directly, which continues from the internal address. Both spaces share one address counter, so loading it through one space moves the position used by the other. Any number of bytes may be streamed while the controller acknowledges each one.

Top module: `i2c_rd_target`

## Requirements
- R1: A select byte is acknowledged only when bits 7..4 equal 1010b (array) or 1011b (identification page) and bits 3..1 equal `chip_en`. Bit 0 is the read flag, where 1 means read. Any other select byte is not acknowledged, and SDA stays released.
- R2: During an address write, the target acknowledges each address byte. The high byte comes first. For the array, bit 15 of the address is ignored, so the loaded address is bits 14..0.
- R3: A random read returns the byte at the loaded address, as the first byte after the second select byte.
- R4: A read that starts without an address write returns the byte at the internal counter. The counter then advances by one.
- R5: While the controller acknowledges each byte, the target returns bytes from consecutive addresses.
- R6: After array address 7FFFh, the next byte comes from address 0000h.
- R7: An identification-page access ignores address bits 15..6. Bits 5..0 select the byte in the page, and sequential reads advance the offset within the page.
- R8: An identification-page access leaves the shared counter at its in-page offset. A later array read without an address write continues from that value.
- R9: After a byte that the controller does not acknowledge, the target releases SDA. After a Stop, it waits for a new Start.
- R10: The target changes SDA only while SCL is low. It leaves SDA released during the controller's acknowledge slot.
- R11: Each read port enable is a single-cycle pulse, asserted only while SCL is low. The two enables are never asserted together, and both are low after reset.
- R12: A Stop in the middle of an address write discards the partial transfer and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| chip_en | input | 3 | Strapped device address bits |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | 15 | Array read address |
| mem_rd_data | input | 8 | Array data, valid one cycle after the strobe |
| id_rd_en | output | 1 | Identification page read strobe |
| id_rd_addr | output | 6 | Identification page offset |
| id_rd_data | input | 8 | Page data, valid one cycle after the strobe |

## Verification
Four properties are checked on every cycle:
- SDA changes only while the synchronised SCL is low.
- SDA is released after a Stop.
- Each read strobe is a single-cycle pulse.
- The two read strobes are exclusive and occur only while SCL is low.

The data behaviour can only be shown by the bench scenarios. This covers the returned bytes, the address loading, the roll-over at 7FFFh, the identification-page offset, the carry-over of the counter between spaces, select rejection and recovery from an aborted address write. For these the bench compares each received byte against a model of the array and the page.

// File: rtl/i2c_rd_pkg.sv
`timescale 1ns/1ps
package i2c_rd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_SEL_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
    ST_HOLD, ST_RD_REQ, ST_RD_LOAD, ST_TX, ST_MACK, ST_MACK_END
  } rd_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe    <= '1;
        prev[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[STAGES-2:0], raw[g]};
        prev[g] <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_addr_ctr.sv
`timescale 1ns/1ps
module i2c_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  input  logic              id_space,
  output logic [ADDR_W-1:0] ctr
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ID_W-1:0]   ID_ONE   = ID_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr <= '0;
    end else if (load) begin
      ctr <= load_val;
    end else if (inc) begin
      if (id_space) ctr <= {ctr[ADDR_W-1:ID_W], ctr[ID_W-1:0] + ID_ONE};
      else          ctr <= ctr + ADDR_ONE;
    end
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
`timescale 1ns/1ps
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int         ADDR_W  = 15,
  parameter int         ID_W    = 6,
  parameter logic [3:0] DEV_MEM = 4'b1010,
  parameter logic [3:0] DEV_ID  = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [2:0]        chip_en,
  input  logic [BYTE_W-1:0] mem_data,
  input  logic [BYTE_W-1:0] id_data,
  output logic              sda_oe,
  output logic              mem_en,
  output logic              id_en,
  output logic              ctr_load,
  output logic [ADDR_W-1:0] ctr_load_val,
  output logic              ctr_inc,
  output logic              id_space
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [3:0] CNT_FULL = 4'd8;
  localparam logic [3:0] CNT_LAST = 4'd7;
  localparam logic [3:0] CNT_ONE  = 4'd1;

  rd_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic [HI_W-1:0]   hi_q;
  logic              rw_q;
  logic              mack_q;
  logic              sel_match;
  logic              sel_is_id;
  logic [BYTE_W-1:0] fetch_data;

  assign sel_is_id  = (shreg[7:4] == DEV_ID);
  assign sel_match  = ((shreg[7:4] == DEV_MEM) || sel_is_id) && (shreg[3:1] == chip_en);
  assign fetch_data = id_space ? id_data : mem_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      bitcnt       <= '0;
      hi_q         <= '0;
      rw_q         <= 1'b0;
      mack_q       <= 1'b0;
      sda_oe       <= 1'b0;
      mem_en       <= 1'b0;
      id_en        <= 1'b0;
      ctr_load     <= 1'b0;
      ctr_load_val <= '0;
      ctr_inc      <= 1'b0;
      id_space     <= 1'b0;
    end else begin
      mem_en   <= 1'b0;
      id_en    <= 1'b0;
      ctr_load <= 1'b0;
      ctr_inc  <= 1'b0;
      if (start_det) begin
        state  <= ST_SEL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE, ST_HOLD: ;
          ST_SEL, ST_AHI, ST_ALO: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + CNT_ONE;
            end else if (scl_fall && bitcnt == CNT_FULL) begin
              if (state == ST_SEL) begin
                if (sel_match) begin
                  sda_oe   <= 1'b1;
                  rw_q     <= shreg[0];
                  id_space <= sel_is_id;
                  state    <= ST_SEL_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_AHI) begin
                hi_q   <= shreg[HI_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_AHI_ACK;
              end else begin
                sda_oe   <= 1'b1;
                ctr_load <= 1'b1;
                if (id_space) ctr_load_val <= {{(ADDR_W-ID_W){1'b0}}, shreg[ID_W-1:0]};
                else          ctr_load_val <= {hi_q, shreg};
                state    <= ST_ALO_ACK;
              end
            end
          end
          ST_SEL_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (rw_q) begin
                mem_en <= ~id_space;
                id_en  <= id_space;
                state  <= ST_RD_REQ;
              end else begin
                state <= ST_AHI;
              end
            end
          end
          ST_AHI_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_ALO;
            end
          end
          ST_ALO_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_HOLD;
            end
          end
          ST_RD_REQ: state <= ST_RD_LOAD;
          ST_RD_LOAD: begin
            shreg   <= fetch_data;
            sda_oe  <= ~fetch_data[BYTE_W-1];
            ctr_inc <= 1'b1;
            bitcnt  <= '0;
            state   <= ST_TX;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == CNT_LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
                bitcnt <= bitcnt + CNT_ONE;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              state  <= ST_MACK_END;
            end
          end
          ST_MACK_END: begin
            if (scl_fall) begin
              if (mack_q) begin
                mem_en <= ~id_space;
                id_en  <= id_space;
                state  <= ST_RD_REQ;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rd_target.sv
`timescale 1ns/1ps
module i2c_rd_target
  import i2c_rd_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         ID_W        = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_MEM     = 4'b1010,
  parameter logic [3:0] DEV_ID      = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              id_rd_en,
  output logic [ID_W-1:0]   id_rd_addr,
  input  logic [BYTE_W-1:0] id_rd_data
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ctr_load, ctr_inc, id_space;
  logic [ADDR_W-1:0] ctr_load_val, ctr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rd_fsm #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DEV_MEM(DEV_MEM), .DEV_ID(DEV_ID)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s), .chip_en(chip_en),
    .mem_data(mem_rd_data), .id_data(id_rd_data), .sda_oe(sda_oe),
    .mem_en(mem_rd_en), .id_en(id_rd_en), .ctr_load(ctr_load),
    .ctr_load_val(ctr_load_val), .ctr_inc(ctr_inc), .id_space(id_space)
  );

  i2c_addr_ctr #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val(ctr_load_val),
    .inc(ctr_inc), .id_space(id_space), .ctr(ctr)
  );

  assign mem_rd_addr = ctr;
  assign id_rd_addr  = ctr[ID_W-1:0];
endmodule

// File: rtl/i2c_rd_target_chk.sv
`timescale 1ns/1ps
module i2c_rd_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic stop_det,
  input logic sda_oe,
  input logic mem_rd_en,
  input logic id_rd_en
);
  // R10
  sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R11
  id_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    id_rd_en |=> !id_rd_en);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_en, id_rd_en}));
  // R11
  strobe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || id_rd_en) |-> !scl_s);
endmodule

bind i2c_rd_target i2c_rd_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .mem_rd_en(mem_rd_en), .id_rd_en(id_rd_en)
);

// File: tb/tb_i2c_rd_target.sv
`timescale 1ns/1ps
module tb_i2c_rd_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 200;
  localparam int QTR  = 100;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_rd_en, id_rd_en;
  logic [14:0] mem_rd_addr;
  logic [5:0]  id_rd_addr;
  logic [7:0]  mem_rd_data = '0, id_rd_data = '0;
  logic sda_bus;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event byte_ev;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_rd_target dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chip_en(CE), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .id_rd_en(id_rd_en), .id_rd_addr(id_rd_addr),
    .id_rd_data(id_rd_data)
  );

  function automatic logic [7:0] mem_val(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction
  function automatic logic [7:0] id_val(input logic [5:0] o);
    return {2'b10, o} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] sel(input bit id, input bit rd);
    return {id ? 4'b1011 : 4'b1010, CE, rd};
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);
    if (id_rd_en)  id_rd_data  <= id_val(id_rd_addr);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(byte_ev);
    if (exp_q.size() == 0) check(0, "R5 unexpected byte", got_byte, 0);
    else check(got_byte == exp_q[0], tag_q[0], got_byte, exp_q[0]);
    if (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #QTR; scl_m = 1'b1; #HALF; sda_m = 1'b0; #HALF; scl_m = 1'b0; #QTR;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; #QTR; scl_m = 1'b1; #HALF; sda_m = 1'b1; #HALF;
  endtask
  task automatic wr_bit(input logic b);
    sda_m = b; #QTR; scl_m = 1'b1; #HALF; scl_m = 1'b0; #QTR;
  endtask
  task automatic rd_bit(output logic b);
    sda_m = 1'b1; #QTR; scl_m = 1'b1; #(HALF/2); b = sda_bus; #(HALF/2); scl_m = 1'b0; #QTR;
  endtask
  task automatic wr_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(a);
    acked = !a;
  endtask
  task automatic rd_byte(input bit give_ack);
    logic [7:0] b;
    logic x;
    for (int i = 7; i >= 0; i--) begin rd_bit(x); b[i] = x; end
    got_byte = b;
    ->byte_ev;
    if (give_ack) wr_bit(1'b0);
    else begin
      rd_bit(x);
      check(x == 1'b1, "R10 released in nack slot", x, 1);
    end
  endtask

  task automatic push(input bit id, input logic [15:0] a, input string tag);
    exp_q.push_back(id ? id_val(a[5:0]) : mem_val(a[14:0]));
    tag_q.push_back(tag);
  endtask

  task automatic read_bytes(input bit id, input logic [15:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ea;
      ea = id ? {10'b0, 6'(a[5:0] + 6'(i))} : {1'b0, 15'(a[14:0] + 15'(i))};
      push(id, ea, tag);
      rd_byte(i < n - 1);
    end
  endtask

  task automatic rand_read(input bit id, input logic [15:0] a, input logic [15:0] ea,
                           input int n, input string tag);
    bit ak;
    bus_start();
    wr_byte(sel(id, 0), ak); check(ak, "R1 select ack", ak, 1);
    wr_byte(a[15:8], ak);    check(ak, "R2 high addr ack", ak, 1);
    wr_byte(a[7:0], ak);     check(ak, "R2 low addr ack", ak, 1);
    bus_start();
    wr_byte(sel(id, 1), ak); check(ak, "R3 read select ack", ak, 1);
    read_bytes(id, ea, n, tag);
    bus_stop();
  endtask

  task automatic cur_read(input bit id, input logic [15:0] ea, input int n, input string tag);
    bit ak;
    bus_start();
    wr_byte(sel(id, 1), ak); check(ak, "R4 select ack", ak, 1);
    read_bytes(id, ea, n, tag);
    bus_stop();
  endtask

  initial begin
    bit ak;
    #1;
    repeat (5) #CLK_PERIOD;
    rst = 1'b0;
    #(CLK_PERIOD * 3);
    // R11 reset state
    check(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
    check(mem_rd_en == 1'b0 && id_rd_en == 1'b0, "R11 reset strobes", {mem_rd_en, id_rd_en}, 0);

    rand_read(0, 16'h1234, 16'h1234, 1, "R3 random read");
    cur_read(0, 16'h1235, 1, "R4 current read");
    rand_read(0, 16'h0100, 16'h0100, 4, "R5 sequential read");
    rand_read(0, 16'h8042, 16'h0042, 1, "R2 A15 ignored");
    rand_read(0, 16'h7FFE, 16'h7FFE, 3, "R6 roll-over");

    // R1 wrong chip enable and wrong device type
    bus_start();
    wr_byte({4'b1010, 3'b011, 1'b1}, ak); check(!ak, "R1 wrong CE no ack", ak, 0);
    bus_stop();
    bus_start();
    wr_byte({4'b0110, CE, 1'b1}, ak); check(!ak, "R1 wrong type no ack", ak, 0);
    bus_stop();
    check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

    rand_read(1, 16'hFFC5, 16'h0005, 3, "R7 id page offset");
    cur_read(0, 16'h0008, 1, "R8 shared counter");

    // R12 abort mid address
    bus_start();
    wr_byte(sel(0, 0), ak); check(ak, "R12 select ack", ak, 1);
    for (int i = 0; i < 4; i++) wr_bit(1'b1);
    bus_stop();
    cur_read(0, 16'h0009, 1, "R12 counter kept after abort");

    #(HALF * 4);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule